// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm, Periodic and Update Interrupts

This block is a calendar timekeeper. It runs from a system clock and is advanced by a clock-enable pulse at 32.768 kHz. A binary divider of `DIV_W` bits turns these ticks into a once-per-second update. The update advances seconds, minutes, hours, day of month, day of week, month and a two-digit year. All fields are held in plain binary.

The block has three interrupt sources:
- A periodic tick taken from the divider, with a programmable rate.
- A time-of-day alarm whose fields can each be wildcarded.
- An update-ended notice raised after each second's update.

Software reaches the block through a byte-wide register port. Through it, software sets the time, the alarm and the control word, reads the sticky flags and clears them. There are two resets. `por_n` is the power-on reset. At power-up it captures the battery-test input into a power-status bit. `rtc_rst_n` clears everything else but leaves that bit untouched.

The once-per-second update is run by a small sequencer with three states:
- `CAL_IDLE` waits for the divider to wrap. It moves to `CAL_ADVANCE` on a second tick, but only while the hold bit is clear.
- `CAL_ADVANCE` applies the full carry chain to the time fields in one step. It always moves to `CAL_COMPARE`.
- `CAL_COMPARE` signals that the update is done. The alarm is checked in this state against the new time. It always moves back to `CAL_IDLE`.

The time fields therefore change one clock after the wrap, and the flags rise one clock after that.

Top module: `cal_rtc`

## Requirements
- R1: While `rtc_rst_n` or `por_n` is low, the following are cleared, and `irq` is low:
  - the time reads 00:00:00, day of month 1, day of week 1, month 1, year 0;
  - the alarm fields, control (address 11) and flags (address 12) read 0.
- R2: On the first clock after `por_n` rises, status bit 7 (address 13) captures the inverse of `bat_test_n`. Bit 7 then keeps its value through any `rtc_rst_n` pulse until the next `por_n`.
- R3: Control bit 7 is the hold bit. While it is 1, the divider sits at zero. After the hold bit is cleared, the first one-second update completes 2^DIV_W ticks later, and one follows every 2^DIV_W ticks after that.
- R4: The time fields sit at addresses 0 to 6, in the order seconds, minutes, hours, day of month, day of week, month, year.
  - A write to these fields takes effect only while the hold bit is 1; with the hold bit 0 it is ignored.
  - No update occurs while the hold bit is 1.
- R5: Seconds and minutes count 0..59 and hours count 0..23, with carry between them. Each carry into a new day advances day of week through 1..7, wrapping to 1.
- R6: Month lengths follow the Gregorian table. February has 29 days when year mod 4 is 0 and 28 otherwise. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0.
- R7: Flag bit 4 (address 12) is set each time a one-second update completes.
- R8: The alarm fields sit at addresses 7 to 10: seconds, minutes, hours, day of month. At update completion, flag bit 5 is set if every alarm field either equals the new time field or has its top two bits at 11 (values 0xC0 to 0xFF), which acts as a wildcard.
- R9: Control bits 3:0 select the periodic rate. A code r from 3 to 15 sets flag bit 6 every 2^(r-1) ticks, counted from divider restart and capped at 2^DIV_W. Codes 0, 1 and 2 never set it.
- R10: A read of address 12 returns the flags, with bit 7 equal to `irq`. The same read clears flag bits 6:4.
- R11: `irq` is the OR of each flag bit 6:4 ANDed with the enable in the same control bit (6 = periodic, 5 = alarm, 4 = update). A set flag whose enable is 0 leaves `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rtc_rst_n | input | 1 | Register reset, active low, asynchronous; spares the power-status bit |
| bat_test_n | input | 1 | Battery test; low at power-up reports a weak battery |
| tick_en | input | 1 | 32.768 kHz clock enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags when addressed) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The calendar advance is tried with a table of starting times, each followed by one second. The table holds:
- a plain seconds step and an hour carry;
- a year-end wrap from 99 to 0;
- the February cases in a leap year and a non-leap year, including leaving February 29;
- the end of a 30-day month and a mid-month day step in a 31-day month.

Taken together, these separate an off-by-one month table, a wrong leap test and a day-of-week wrap fault.

The alarm is tried with four setups:
- an exact match;
- an exact seconds mismatch;
- all fields wildcarded;
- a wildcard seconds field with a mismatching hours field.

These separate a broken comparison from a broken wildcard decode.

The periodic rate is timed across two codes and the off code. The hold and restart behaviour is timed just before and just after the expected second boundary.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        CAL_IDLE    = 2'd0,
        CAL_ADVANCE = 2'd1,
        CAL_COMPARE = 2'd2
    } cal_state_e;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] wday;
        logic [7:0] mday;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_MIN   = 4'd1;
    localparam logic [3:0] A_HOUR  = 4'd2;
    localparam logic [3:0] A_MDAY  = 4'd3;
    localparam logic [3:0] A_WDAY  = 4'd4;
    localparam logic [3:0] A_MONTH = 4'd5;
    localparam logic [3:0] A_YEAR  = 4'd6;
    localparam logic [3:0] A_ASEC  = 4'd7;
    localparam logic [3:0] A_AMIN  = 4'd8;
    localparam logic [3:0] A_AHOUR = 4'd9;
    localparam logic [3:0] A_AMDAY = 4'd10;
    localparam logic [3:0] A_CTRL  = 4'd11;
    localparam logic [3:0] A_FLAG  = 4'd12;
    localparam logic [3:0] A_STAT  = 4'd13;

    localparam int ALARM_FIELDS = 4;

    function automatic logic [7:0] month_days(input logic [7:0] month, input logic [7:0] year);
        logic [7:0] n;
        case (month)
            8'd4, 8'd6, 8'd9, 8'd11: n = 8'd30;
            8'd2:                    n = (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            default:                 n = 8'd31;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
module rtc_divider #(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       hold,
    input  logic [3:0] rate,
    output logic       sec_tick,
    output logic       per_tick
);
    localparam logic [4:0] SH_MAX = 5'(DIV_W);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_nx;
    logic [DIV_W-1:0] tap_mask;
    logic [4:0]       shift;

    assign div_nx = div_q + DIV_W'(1);
    assign shift  = {1'b0, rate} - 5'd1;

    always_comb begin
        if (shift >= SH_MAX) tap_mask = '1;
        else                 tap_mask = (DIV_W'(1) << shift) - DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (hold)    div_q <= '0;
        else if (tick_en) div_q <= div_nx;
    end

    assign sec_tick = tick_en && !hold && (div_q == '1);
    assign per_tick = tick_en && !hold && (rate >= 4'd3) && ((div_nx & tap_mask) == '0);

    assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (div_q == '0));

    assert_wrap_after_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (div_q == '0));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       set_mode,
    input  logic       wr_en,
    input  logic [3:0] waddr,
    input  logic [7:0] wdata,
    output rtc_time_t  now,
    output logic       upd_done
);
    cal_state_e state_q, state_d;
    rtc_time_t  tm_q, tm_adv;
    logic [7:0] dim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAL_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAL_IDLE:    if (sec_tick && !set_mode) state_d = CAL_ADVANCE;
            CAL_ADVANCE: state_d = CAL_COMPARE;
            CAL_COMPARE: state_d = CAL_IDLE;
            default:     state_d = CAL_IDLE;
        endcase
    end

    assign upd_done = (state_q == CAL_COMPARE);
    assign now      = tm_q;
    assign dim      = month_days(tm_q.month, tm_q.year);

    always_comb begin
        tm_adv = tm_q;
        if (tm_q.sec < 8'd59) begin
            tm_adv.sec = tm_q.sec + 8'd1;
        end else begin
            tm_adv.sec = 8'd0;
            if (tm_q.min < 8'd59) begin
                tm_adv.min = tm_q.min + 8'd1;
            end else begin
                tm_adv.min = 8'd0;
                if (tm_q.hour < 8'd23) begin
                    tm_adv.hour = tm_q.hour + 8'd1;
                end else begin
                    tm_adv.hour = 8'd0;
                    tm_adv.wday = (tm_q.wday >= 8'd7) ? 8'd1 : tm_q.wday + 8'd1;
                    if (tm_q.mday < dim) begin
                        tm_adv.mday = tm_q.mday + 8'd1;
                    end else begin
                        tm_adv.mday = 8'd1;
                        if (tm_q.month < 8'd12) begin
                            tm_adv.month = tm_q.month + 8'd1;
                        end else begin
                            tm_adv.month = 8'd1;
                            tm_adv.year  = (tm_q.year >= 8'd99) ? 8'd0 : tm_q.year + 8'd1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '{year: 8'd0, month: 8'd1, wday: 8'd1, mday: 8'd1,
                      hour: 8'd0, min: 8'd0, sec: 8'd0};
        end else if (wr_en && set_mode && waddr <= A_YEAR) begin
            case (waddr)
                A_SEC:   tm_q.sec   <= wdata;
                A_MIN:   tm_q.min   <= wdata;
                A_HOUR:  tm_q.hour  <= wdata;
                A_MDAY:  tm_q.mday  <= wdata;
                A_WDAY:  tm_q.wday  <= wdata;
                A_MONTH: tm_q.month <= wdata;
                default: tm_q.year  <= wdata;
            endcase
        end else if (state_q == CAL_ADVANCE) begin
            tm_q <= tm_adv;
        end
    end

    assert_tick_starts_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !set_mode && state_q == CAL_IDLE) |=> (state_q == CAL_ADVANCE));

    assert_no_update_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mode && state_q == CAL_IDLE) |=> (state_q != CAL_ADVANCE));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  rtc_time_t                        now,
    input  logic [ALARM_FIELDS-1:0][7:0]     alarm,
    output logic                             hit
);
    logic [ALARM_FIELDS-1:0][7:0] cur;
    logic [ALARM_FIELDS-1:0]      fld_ok;

    assign cur = {now.mday, now.hour, now.min, now.sec};

    for (genvar i = 0; i < ALARM_FIELDS; i++) begin : g_field
        assign fld_ok[i] = (alarm[i][7:6] == 2'b11) || (alarm[i] == cur[i]);
    end

    assign hit = &fld_ok;

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import rtc_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rtc_rst_n,
    input  logic       bat_test_n,
    input  logic       tick_en,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    localparam int NFLAG = 3;

    logic                         core_rst_n;
    logic [7:0]                   ctrl_q;
    logic [ALARM_FIELDS-1:0][7:0] alarm_q;
    logic [NFLAG-1:0]             flags_q;
    logic [NFLAG-1:0]             flag_set;
    logic                         ps_q, seen_q;
    logic                         sec_tick, per_tick, upd_done, alarm_hit, flag_clr;
    rtc_time_t                    now;

    assign core_rst_n = por_n & rtc_rst_n;

    rtc_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .tick_en  (tick_en),
        .hold     (ctrl_q[7]),
        .rate     (ctrl_q[3:0]),
        .sec_tick (sec_tick),
        .per_tick (per_tick)
    );

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (core_rst_n),
        .sec_tick (sec_tick),
        .set_mode (ctrl_q[7]),
        .wr_en    (wr_en),
        .waddr    (addr),
        .wdata    (wdata),
        .now      (now),
        .upd_done (upd_done)
    );

    rtc_alarm_match u_alm (
        .now   (now),
        .alarm (alarm_q),
        .hit   (alarm_hit)
    );

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            ctrl_q  <= '0;
            alarm_q <= '0;
        end else if (wr_en) begin
            if (addr == A_CTRL) ctrl_q <= wdata;
            if (addr >= A_ASEC && addr <= A_AMDAY) alarm_q[addr - A_ASEC] <= wdata;
        end
    end

    assign flag_set = {per_tick, upd_done && alarm_hit, upd_done};
    assign flag_clr = rd_en && (addr == A_FLAG);

    always_ff @(posedge clk or negedge core_rst_n) begin
        if (!core_rst_n) flags_q <= '0;
        else             flags_q <= (flag_clr ? '0 : flags_q) | flag_set;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ps_q   <= 1'b0;
            seen_q <= 1'b0;
        end else if (!seen_q) begin
            ps_q   <= ~bat_test_n;
            seen_q <= 1'b1;
        end
    end

    assign irq = |(flags_q & ctrl_q[6:4]);

    always_comb begin
        case (addr)
            A_SEC:   rdata = now.sec;
            A_MIN:   rdata = now.min;
            A_HOUR:  rdata = now.hour;
            A_MDAY:  rdata = now.mday;
            A_WDAY:  rdata = now.wday;
            A_MONTH: rdata = now.month;
            A_YEAR:  rdata = now.year;
            A_ASEC:  rdata = alarm_q[0];
            A_AMIN:  rdata = alarm_q[1];
            A_AHOUR: rdata = alarm_q[2];
            A_AMDAY: rdata = alarm_q[3];
            A_CTRL:  rdata = ctrl_q;
            A_FLAG:  rdata = {irq, flags_q, 4'b0000};
            A_STAT:  rdata = {ps_q, 7'b0000000};
            default: rdata = 8'h00;
        endcase
    end

    assert_update_flag_R7: assert property (@(posedge clk) disable iff (!core_rst_n)
        upd_done |=> flags_q[0]);

    assert_alarm_on_update_R8: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(flags_q[1]) |-> $past(upd_done));

    assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(irq) |-> (|ctrl_q[6:4]));

    assert_power_flag_sticky_R2: assert property (@(posedge clk) disable iff (!por_n)
        seen_q |=> $stable(ps_q));

endmodule

// File: tb/cal_rtc_test.sv
module cal_rtc_test;
    localparam int TB_DIV_W = 8;
    localparam int SEC_WAIT = (1 << TB_DIV_W) + 14;

    logic       clk = 1'b0;
    logic       por_n, rtc_rst_n, bat_test_n, tick_en, wr_en, rd_en;
    logic [3:0] addr;
    logic [7:0] wdata, rdata, got;
    logic       irq;
    int         total = 0;
    int         bad = 0;

    cal_rtc #(.DIV_W(TB_DIV_W)) uut (
        .clk(clk), .por_n(por_n), .rtc_rst_n(rtc_rst_n), .bat_test_n(bat_test_n),
        .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    // start {sec,min,hour,mday,wday,month,year}, then expected one second later
    localparam logic [111:0] VEC [0:7] = '{
        {8'd30, 8'd20, 8'd10, 8'd5,  8'd3, 8'd6,  8'd21,  8'd31, 8'd20, 8'd10, 8'd5,  8'd3, 8'd6, 8'd21},
        {8'd59, 8'd59, 8'd12, 8'd5,  8'd3, 8'd6,  8'd21,  8'd0,  8'd0,  8'd13, 8'd5,  8'd3, 8'd6, 8'd21},
        {8'd59, 8'd59, 8'd23, 8'd31, 8'd7, 8'd12, 8'd99,  8'd0,  8'd0,  8'd0,  8'd1,  8'd1, 8'd1, 8'd0},
        {8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 8'd2,  8'd24,  8'd0,  8'd0,  8'd0,  8'd29, 8'd3, 8'd2, 8'd24},
        {8'd59, 8'd59, 8'd23, 8'd28, 8'd2, 8'd2,  8'd23,  8'd0,  8'd0,  8'd0,  8'd1,  8'd3, 8'd3, 8'd23},
        {8'd59, 8'd59, 8'd23, 8'd30, 8'd4, 8'd4,  8'd10,  8'd0,  8'd0,  8'd0,  8'd1,  8'd5, 8'd5, 8'd10},
        {8'd59, 8'd59, 8'd23, 8'd29, 8'd6, 8'd2,  8'd24,  8'd0,  8'd0,  8'd0,  8'd1,  8'd7, 8'd3, 8'd24},
        {8'd59, 8'd59, 8'd23, 8'd30, 8'd5, 8'd1,  8'd5,   8'd0,  8'd0,  8'd0,  8'd31, 8'd6, 8'd1, 8'd5}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_time(input logic [55:0] t);
        wr(4'd11, 8'h80);
        for (int k = 0; k < 7; k++) wr(4'(k), t[55-8*k -: 8]);
    endtask

    task automatic power_up(input logic bat);
        por_n = 1'b0; rtc_rst_n = 1'b0; bat_test_n = bat;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rtc_rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        power_up(1'b0);

        // R1 reset state
        rd(4'd0, got); chk("R1 sec", got, 8'd0);
        rd(4'd2, got); chk("R1 hour", got, 8'd0);
        rd(4'd3, got); chk("R1 mday", got, 8'd1);
        rd(4'd4, got); chk("R1 wday", got, 8'd1);
        rd(4'd5, got); chk("R1 month", got, 8'd1);
        rd(4'd11, got); chk("R1 ctrl", got, 8'h00);
        rd(4'd12, got); chk("R1 flags", got, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'd0);
        // R2 weak battery captured
        rd(4'd13, got); chk("R2 status weak", got, 8'h80);

        // R4 time write ignored with hold bit clear
        wr(4'd0, 8'd5);
        rd(4'd0, got); chk("R4 write ignored", got, 8'd0);

        // R1/R2 register reset spares power status
        wr(4'd11, 8'h80); wr(4'd7, 8'd9);
        rtc_rst_n = 1'b0; repeat (2) @(negedge clk); rtc_rst_n = 1'b1;
        rd(4'd11, got); chk("R1 ctrl after rst", got, 8'h00);
        rd(4'd7, got); chk("R1 alarm after rst", got, 8'h00);
        rd(4'd13, got); chk("R2 status kept", got, 8'h80);
        power_up(1'b1);
        rd(4'd13, got); chk("R2 status good", got, 8'h00);

        // R4 hold freezes time
        wr(4'd11, 8'h80);
        rd(4'd12, got);
        wr(4'd0, 8'd10);
        repeat (600) @(negedge clk);
        rd(4'd0, got); chk("R4 held sec", got, 8'd10);
        rd(4'd12, got); chk("R4 no update in hold", got, 8'h00);

        // R3 restart timing
        wr(4'd11, 8'h00);
        repeat (240) @(negedge clk);
        rd(4'd0, got); chk("R3 before second", got, 8'd10);
        repeat (30) @(negedge clk);
        rd(4'd0, got); chk("R3 after second", got, 8'd11);
        rd(4'd12, got); chk("R7 update flag", got, 8'h10);
        rd(4'd12, got); chk("R10 read cleared", got, 8'h00);

        // R5 R6 calendar vectors
        for (int v = 0; v < 8; v++) begin
            set_time(VEC[v][111:56]);
            wr(4'd11, 8'h00);
            repeat (SEC_WAIT) @(negedge clk);
            for (int k = 0; k < 7; k++) begin
                rd(4'(k), got);
                chk((v < 3) ? "R5 carry" : "R6 month/leap", got, VEC[v][55-8*k -: 8]);
            end
        end

        // R8 alarm exact match, R11 irq
        set_time({8'd3, 8'd2, 8'd1, 8'd5, 8'd2, 8'd3, 8'd20});
        wr(4'd7, 8'd4); wr(4'd8, 8'd2); wr(4'd9, 8'd1); wr(4'd10, 8'hFF);
        rd(4'd12, got);
        wr(4'd11, 8'h20);
        repeat (SEC_WAIT) @(negedge clk);
        chk("R11 irq on alarm", {7'd0, irq}, 8'd1);
        rd(4'd12, got); chk("R8 exact alarm", got, 8'hB0);

        // R8 seconds mismatch
        set_time({8'd3, 8'd2, 8'd1, 8'd5, 8'd2, 8'd3, 8'd20});
        wr(4'd7, 8'd50);
        rd(4'd12, got);
        wr(4'd11, 8'h20);
        repeat (SEC_WAIT) @(negedge clk);
        chk("R11 irq idle", {7'd0, irq}, 8'd0);
        rd(4'd12, got); chk("R8 mismatch", got, 8'h10);

        // R8 full wildcard
        set_time({8'd3, 8'd2, 8'd1, 8'd5, 8'd2, 8'd3, 8'd20});
        wr(4'd7, 8'hC5); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hD0);
        rd(4'd12, got);
        wr(4'd11, 8'h20);
        repeat (SEC_WAIT) @(negedge clk);
        rd(4'd12, got); chk("R8 wildcard", got, 8'hB0);

        // R8 wildcard seconds, hours mismatch
        set_time({8'd3, 8'd2, 8'd1, 8'd5, 8'd2, 8'd3, 8'd20});
        wr(4'd7, 8'hFF); wr(4'd9, 8'd7);
        rd(4'd12, got);
        wr(4'd11, 8'h20);
        repeat (SEC_WAIT) @(negedge clk);
        rd(4'd12, got); chk("R8 hour mismatch", got, 8'h10);

        // R9 periodic code 6 (every 32 ticks)
        wr(4'd11, 8'h86); rd(4'd12, got);
        wr(4'd11, 8'h46);
        repeat (20) @(negedge clk);
        chk("R9 code6 early", {7'd0, irq}, 8'd0);
        repeat (20) @(negedge clk);
        chk("R9 code6 fired", {7'd0, irq}, 8'd1);
        rd(4'd12, got); chk("R9 code6 flags", got, 8'hC0);

        // R9 periodic code 3 (every 4 ticks)
        wr(4'd11, 8'h83); rd(4'd12, got);
        wr(4'd11, 8'h43);
        repeat (2) @(negedge clk);
        chk("R9 code3 early", {7'd0, irq}, 8'd0);
        repeat (3) @(negedge clk);
        chk("R9 code3 fired", {7'd0, irq}, 8'd1);

        // R9 code 0 off; R11 update flag without enable keeps irq low
        wr(4'd11, 8'h80); rd(4'd12, got);
        wr(4'd11, 8'h40);
        repeat (300) @(negedge clk);
        chk("R11 masked irq", {7'd0, irq}, 8'd0);
        rd(4'd12, got); chk("R9 code0 off", got, 8'h10);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule